// File: doc/BRIEF.md
# Colour-Keyed Rectangle Blitter

This block draws a list of rectangular pixel objects into the hidden half of a two-page frame store while the other page is on screen. Software fills a table of object slots. Each slot holds an on-screen position, a width, a height, a source pointer and an enable bit. Software then pulses a start input. The blitter visits every slot in index order. For each enabled, non-empty slot it walks the rectangle one row after another, reads each 8-bit source pixel through a synchronous memory port, and writes it to the back page.

A programmable key colour makes pixels transparent. A source pixel that matches the key is simply not written, so whatever the back page already holds stays visible. Pixels whose screen position lands outside the 400×300 visible area are dropped in the same way. Nothing is blended. Software is expected to repaint the background into the back page each frame before it starts the object pass.

A page-flip request is held until a rising edge of the vertical-blank input arrives while the blitter is idle. At that point the displayed and hidden pages change roles.

Top module: `colorkey_blitter`

## Requirements
- R1: After reset, busy, done, fb_we and src_re are low, disp_sel is 0 (page 0 shown, page 1 hidden), every slot is disabled and the key register holds 0x00.
- R2: Every frame-store write targets the hidden page. The hidden page base is 120000 when disp_sel is 0 and 0 when disp_sel is 1. The address is base + (y+row)*400 + (x+col).
- R3: Slots are drawn in ascending index order. Inside a slot the walk is row by row, with columns in ascending order, and the source pixel for (row, col) is read from src + row*w + col (modulo 2^20). Later slots therefore overwrite earlier ones.
- R4: A source pixel equal to the key register is not written. The key is loaded from key_val when key_we is high, and it resets to 0x00.
- R5: The written data always equals the source pixel exactly, with no mixing with the destination.
- R6: A pixel whose screen x is 400 or more, or whose screen y is 300 or more, is not written. Its neighbours inside the area are still written.
- R7: A start pulse while idle raises busy on the next cycle. Without stalls busy lasts exactly 16 + 2*P cycles, where P is the number of pixels in all drawn rectangles (clipped and transparent ones included). done is high for the single cycle in which busy has just fallen. A start pulse while busy has no effect.
- R8: A slot with its enable bit clear, or with width 0 or height 0, produces no read and no write and costs one cycle.
- R9: A page-flip request toggles disp_sel on a rising edge of vblank seen while idle. If the edge comes while busy, the flip happens on the first idle cycle after. disp_sel never changes while busy, and it does not change without a vblank edge.
- R10: Each pixel uses one src_re cycle, then one write cycle. src_rdata holds the pixel of the last accepted read. While stall is high, src_re and fb_we stay low and the walk holds its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_we | input | 1 | Write strobe for the object slot table |
| desc_idx | input | 4 | Slot index being written |
| desc_valid | input | 1 | Slot enable bit |
| desc_x | input | 9 | Screen column of the rectangle's top-left pixel |
| desc_y | input | 9 | Screen row of the rectangle's top-left pixel |
| desc_w | input | 8 | Rectangle width in pixels |
| desc_h | input | 8 | Rectangle height in pixels |
| desc_src | input | 20 | Source address of the first pixel |
| key_we | input | 1 | Load strobe for the transparent key |
| key_val | input | 8 | New transparent key value |
| start | input | 1 | Begin a pass over the slot table |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when a pass ends |
| swap_req | input | 1 | Request a page flip |
| vblank | input | 1 | Vertical blank level from video timing |
| disp_sel | output | 1 | Page currently on screen |
| stall | input | 1 | Memory port not granted this cycle |
| src_re | output | 1 | Source read strobe |
| src_addr | output | 20 | Source read address |
| src_rdata | input | 8 | Pixel of the last accepted source read |
| fb_we | output | 1 | Frame-store write strobe |
| fb_addr | output | 18 | Frame-store write address |
| fb_wdata | output | 8 | Frame-store write data |

## Verification
The bench builds the block with its default parameters: 16 slots and a 400×300 page, so the two pages together span 240000 addresses. These values put the right and bottom clip edges within reach of 8-bit sizes, including a rectangle whose start column already lies beyond the visible width. They also let slot 15 be the last drawn entry, and let a pixel pattern hit both the reset key 0x00 and a loaded key of 0x55. Random stalls, a start pulse in mid-pass and a page flip requested during a pass check that the walk and the page selection hold exactly.

// File: rtl/colorkey_blitter_pkg.sv
package colorkey_blitter_pkg;

  localparam int X_W   = 9;
  localparam int Y_W   = 9;
  localparam int SZ_W  = 8;
  localparam int SRC_W = 20;
  localparam int PIX_W = 8;
  localparam int POS_W = X_W + 1;

  typedef struct packed {
    logic             valid;
    logic [X_W-1:0]   x;
    logic [Y_W-1:0]   y;
    logic [SZ_W-1:0]  w;
    logic [SZ_W-1:0]  h;
    logic [SRC_W-1:0] src;
  } obj_slot_t;

  // linear frame-store address of a screen pixel inside a page
  function automatic int unsigned page_addr(input int unsigned base,
                                            input int unsigned px,
                                            input int unsigned py,
                                            input int unsigned scr_w);
    return base + py * scr_w + px;
  endfunction

  // true when the pixel lies in the visible area
  function automatic logic on_screen(input int unsigned px,
                                     input int unsigned py,
                                     input int unsigned scr_w,
                                     input int unsigned scr_h);
    return (px < scr_w) && (py < scr_h);
  endfunction

endpackage

// File: rtl/blit_slot_table.sv
module blit_slot_table
  import colorkey_blitter_pkg::*;
#(
  parameter int N_OBJ = 16,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  obj_slot_t        wr_slot,
  input  logic [IDX_W-1:0] rd_idx,
  output obj_slot_t        rd_slot
);

  obj_slot_t slots [N_OBJ];

  for (genvar g = 0; g < N_OBJ; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slots[g] <= wr_slot;
      end
    end
  end

  assign rd_slot = slots[rd_idx];

endmodule

// File: rtl/blit_page_flip.sv
module blit_page_flip (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_req,
  input  logic vblank,
  input  logic idle,
  output logic disp_sel,
  output logic flip_ev
);

  logic vb_q;
  logic pend_q;
  logic armed_q;
  logic vb_rise;

  assign vb_rise = vblank & ~vb_q;
  assign flip_ev = (armed_q | (vb_rise & pend_q)) & idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q     <= 1'b0;
      pend_q   <= 1'b0;
      armed_q  <= 1'b0;
      disp_sel <= 1'b0;
    end else begin
      vb_q    <= vblank;
      pend_q  <= (pend_q & ~flip_ev) | swap_req;
      armed_q <= (armed_q | (vb_rise & pend_q)) & ~flip_ev;
      if (flip_ev) begin
        disp_sel <= ~disp_sel;
      end
    end
  end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
  import colorkey_blitter_pkg::*;
#(
  parameter int N_OBJ = 16,
  parameter int SCR_W = 400,
  parameter int SCR_H = 300,
  parameter int FB_AW = 18,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stall,
  input  obj_slot_t        slot,
  input  logic [PIX_W-1:0] key,
  input  logic [FB_AW-1:0] back_base,
  input  logic [PIX_W-1:0] src_rdata,
  output logic [IDX_W-1:0] slot_idx,
  output logic             busy,
  output logic             done,
  output logic             src_re,
  output logic [SRC_W-1:0] src_addr,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr,
  output logic [PIX_W-1:0] fb_wdata
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_READ, S_WRITE} walk_st_t;

  walk_st_t         st;
  logic [IDX_W-1:0] idx;
  logic [SZ_W-1:0]  row, col;
  logic [X_W-1:0]   cur_x;
  logic [Y_W-1:0]   cur_y;
  logic [SZ_W-1:0]  cur_w, cur_h;
  logic [SRC_W-1:0] src_ptr;
  logic             done_q;

  logic [POS_W-1:0] px, py;
  logic             visible, opaque;
  logic             slot_ok, last_col, last_row, last_idx;

  assign px       = POS_W'(cur_x) + POS_W'(col);
  assign py       = POS_W'(cur_y) + POS_W'(row);
  assign visible  = on_screen(int'(px), int'(py), SCR_W, SCR_H);
  assign opaque   = (src_rdata != key);
  assign slot_ok  = slot.valid && (slot.w != '0) && (slot.h != '0);
  assign last_col = (col == cur_w - 1'b1);
  assign last_row = (row == cur_h - 1'b1);
  assign last_idx = (idx == IDX_W'(N_OBJ - 1));

  assign slot_idx = idx;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign src_re   = (st == S_READ) && !stall;
  assign src_addr = src_ptr;
  assign fb_we    = (st == S_WRITE) && !stall && visible && opaque;
  assign fb_addr  = FB_AW'(page_addr(int'(back_base), int'(px), int'(py), SCR_W));
  assign fb_wdata = src_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      row     <= '0;
      col     <= '0;
      cur_x   <= '0;
      cur_y   <= '0;
      cur_w   <= '0;
      cur_h   <= '0;
      src_ptr <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            idx <= '0;
            st  <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (slot_ok) begin
            cur_x   <= slot.x;
            cur_y   <= slot.y;
            cur_w   <= slot.w;
            cur_h   <= slot.h;
            src_ptr <= slot.src;
            row     <= '0;
            col     <= '0;
            st      <= S_READ;
          end else if (last_idx) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_READ: begin
          if (!stall) st <= S_WRITE;
        end
        S_WRITE: begin
          if (!stall) begin
            src_ptr <= src_ptr + 1'b1;
            st      <= S_READ;
            if (!last_col) begin
              col <= col + 1'b1;
            end else begin
              col <= '0;
              if (!last_row) begin
                row <= row + 1'b1;
              end else begin
                row <= '0;
                if (last_idx) begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
                end else begin
                  idx <= idx + 1'b1;
                  st  <= S_SCAN;
                end
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/colorkey_blitter.sv
module colorkey_blitter
  import colorkey_blitter_pkg::*;
#(
  parameter int N_OBJ = 16,
  parameter int SCR_W = 400,
  parameter int SCR_H = 300,
  localparam int IDX_W     = $clog2(N_OBJ),
  localparam int FRAME_PIX = SCR_W * SCR_H,
  localparam int FB_AW     = $clog2(2 * FRAME_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_we,
  input  logic [IDX_W-1:0] desc_idx,
  input  logic             desc_valid,
  input  logic [X_W-1:0]   desc_x,
  input  logic [Y_W-1:0]   desc_y,
  input  logic [SZ_W-1:0]  desc_w,
  input  logic [SZ_W-1:0]  desc_h,
  input  logic [SRC_W-1:0] desc_src,
  input  logic             key_we,
  input  logic [PIX_W-1:0] key_val,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             swap_req,
  input  logic             vblank,
  output logic             disp_sel,
  input  logic             stall,
  output logic             src_re,
  output logic [SRC_W-1:0] src_addr,
  input  logic [PIX_W-1:0] src_rdata,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr,
  output logic [PIX_W-1:0] fb_wdata
);

  obj_slot_t        wr_slot, rd_slot;
  logic [IDX_W-1:0] rd_idx;
  logic [PIX_W-1:0] key_q;
  logic [FB_AW-1:0] back_base;
  logic             idle;
  logic             flip_ev;

  assign wr_slot = '{valid: desc_valid, x: desc_x, y: desc_y,
                     w: desc_w, h: desc_h, src: desc_src};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_we) key_q <= key_val;
  end

  assign idle      = !busy && !start;
  assign back_base = disp_sel ? '0 : FB_AW'(FRAME_PIX);

  blit_slot_table #(.N_OBJ(N_OBJ)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (desc_we),
    .wr_idx  (desc_idx),
    .wr_slot (wr_slot),
    .rd_idx  (rd_idx),
    .rd_slot (rd_slot)
  );

  blit_page_flip u_flip (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_req (swap_req),
    .vblank   (vblank),
    .idle     (idle),
    .disp_sel (disp_sel),
    .flip_ev  (flip_ev)
  );

  blit_walker #(
    .N_OBJ (N_OBJ),
    .SCR_W (SCR_W),
    .SCR_H (SCR_H),
    .FB_AW (FB_AW)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stall     (stall),
    .slot      (rd_slot),
    .key       (key_q),
    .back_base (back_base),
    .src_rdata (src_rdata),
    .slot_idx  (rd_idx),
    .busy      (busy),
    .done      (done),
    .src_re    (src_re),
    .src_addr  (src_addr),
    .fb_we     (fb_we),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata)
  );

endmodule

// File: rtl/colorkey_blitter_chk.sv
module colorkey_blitter_chk #(
  parameter int FRAME_PIX = 120000,
  parameter int FB_AW     = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             disp_sel,
  input logic             flip_ev,
  input logic             stall,
  input logic             src_re,
  input logic             fb_we,
  input logic [FB_AW-1:0] fb_addr,
  input logic [7:0]       fb_wdata,
  input logic [7:0]       key
);

  p_back_page_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (disp_sel ? (32'(fb_addr) < FRAME_PIX)
                        : (32'(fb_addr) >= FRAME_PIX && 32'(fb_addr) < 2 * FRAME_PIX)));

  p_key_never_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (fb_wdata != key));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_page_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(disp_sel));

  p_flip_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ev |-> !busy);

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!src_re && !fb_we));

  p_read_then_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src_re |=> !src_re);

endmodule

bind colorkey_blitter colorkey_blitter_chk #(
  .FRAME_PIX (FRAME_PIX),
  .FB_AW     (FB_AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .disp_sel (disp_sel),
  .flip_ev  (flip_ev),
  .stall    (stall),
  .src_re   (src_re),
  .fb_we    (fb_we),
  .fb_addr  (fb_addr),
  .fb_wdata (fb_wdata),
  .key      (key_q)
);

// File: tb/colorkey_blitter_tb.sv
`timescale 1ns/1ps
module colorkey_blitter_tb;

  localparam int FRAME = 120000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [3:0]  desc_idx = '0;
  logic        desc_valid = 1'b0;
  logic [8:0]  desc_x = '0;
  logic [8:0]  desc_y = '0;
  logic [7:0]  desc_w = '0;
  logic [7:0]  desc_h = '0;
  logic [19:0] desc_src = '0;
  logic        key_we = 1'b0;
  logic [7:0]  key_val = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic        swap_req = 1'b0;
  logic        vblank = 1'b0;
  logic        disp_sel;
  logic        stall;
  logic        src_re;
  logic [19:0] src_addr;
  logic [7:0]  src_rdata = '0;
  logic        fb_we;
  logic [17:0] fb_addr;
  logic [7:0]  fb_wdata;

  colorkey_blitter u_dut (
    .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_valid(desc_valid), .desc_x(desc_x), .desc_y(desc_y),
    .desc_w(desc_w), .desc_h(desc_h), .desc_src(desc_src),
    .key_we(key_we), .key_val(key_val), .start(start), .busy(busy),
    .done(done), .swap_req(swap_req), .vblank(vblank), .disp_sel(disp_sel),
    .stall(stall), .src_re(src_re), .src_addr(src_addr),
    .src_rdata(src_rdata), .fb_we(fb_we), .fb_addr(fb_addr),
    .fb_wdata(fb_wdata)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // source memory: every fourth address holds 0x00, the rest odd values
  function automatic logic [7:0] pix_of(input logic [19:0] a);
    if (a[1:0] == 2'b00) return 8'h00;
    return a[7:0] | 8'h01;
  endfunction

  always @(posedge clk) if (src_re) src_rdata <= pix_of(src_addr);

  logic       stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign stall = stall_en & lfsr[0];

  // bench-side copy of what software wrote
  int bx[16], by[16], bw[16], bh[16], bsrc[16];
  bit bv[16];
  int key_m = 0;

  int exp_addr[$];
  int exp_data[$];
  bit m_disp = 0, m_pend = 0, m_arm = 0, m_vbq = 0;
  bit rise_m, go_m;
  bit mon_on = 0;
  int busy_cnt = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (fb_we) begin
        if (exp_addr.size() == 0) begin
          chk(0, "R3", "unexpected write at addr", fb_addr, -1);
        end else begin
          chk(fb_addr == exp_addr[0], "R2", "write address", fb_addr, exp_addr[0]);
          chk(fb_wdata == exp_data[0], "R5", "write data", fb_wdata, exp_data[0]);
          void'(exp_addr.pop_front());
          void'(exp_data.pop_front());
        end
      end
      chk(disp_sel == m_disp, "R9", "disp_sel", disp_sel, m_disp);
      if (busy) busy_cnt++;
      rise_m = vblank && !m_vbq;
      m_vbq  = vblank;
      go_m   = (m_arm || (rise_m && m_pend)) && !busy && !start;
      if (rise_m && m_pend) m_arm = 1;
      if (go_m) begin
        m_disp = !m_disp;
        m_arm  = 0;
        m_pend = 0;
      end
      if (swap_req) m_pend = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_slot(input int i, input int x, input int y, input int w,
                          input int h, input int src, input bit v);
    tick();
    desc_we = 1; desc_idx = 4'(i); desc_valid = v; desc_x = 9'(x);
    desc_y = 9'(y); desc_w = 8'(w); desc_h = 8'(h); desc_src = 20'(src);
    tick();
    desc_we = 0;
    bx[i] = x; by[i] = y; bw[i] = w; bh[i] = h; bsrc[i] = src; bv[i] = v;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) set_slot(i, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic set_key(input int k);
    tick();
    key_we = 1; key_val = 8'(k);
    tick();
    key_we = 0;
    key_m = k;
  endtask

  // builds the expected write list, runs one pass, checks length and queue
  task automatic run_pass(input bit time_it, input bit restart_mid, input string req);
    int base, p, px, py, a;
    int n;
    n = 0;
    base = m_disp ? 0 : FRAME;
    for (int i = 0; i < 16; i++) begin
      if (bv[i] && bw[i] > 0 && bh[i] > 0) begin
        for (int r = 0; r < bh[i]; r++) begin
          for (int c = 0; c < bw[i]; c++) begin
            n++;
            px = bx[i] + c;
            py = by[i] + r;
            a = (bsrc[i] + r * bw[i] + c) & 32'hFFFFF;
            p = int'(pix_of(20'(a)));
            if (px < 400 && py < 300 && p != key_m) begin
              exp_addr.push_back(base + py * 400 + px);
              exp_data.push_back(p);
            end
          end
        end
      end
    end
    busy_cnt = 0;
    tick();
    start = 1;
    tick();
    start = 0;
    if (restart_mid) begin
      repeat (20) tick();
      start = 1;
      tick();
      start = 0;
    end
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1, req, "done pulse seen", done, 1);
    chk(busy == 0, req, "busy low with done", busy, 0);
    chk(exp_addr.size() == 0, req, "writes left over", exp_addr.size(), 0);
    if (time_it) chk(busy_cnt == 16 + 2 * n, "R7", "busy cycles", busy_cnt, 16 + 2 * n);
    exp_addr.delete();
    exp_data.delete();
    @(negedge clk);
    chk(done == 0, "R7", "done single cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      bv[i] = 0; bx[i] = 0; by[i] = 0; bw[i] = 0; bh[i] = 0; bsrc[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(disp_sel == 0, "R1", "disp_sel", disp_sel, 0);
    chk(fb_we == 0, "R1", "fb_we", fb_we, 0);
    chk(src_re == 0, "R1", "src_re", src_re, 0);
    mon_on = 1;

    // R1 R4: slots reset disabled (empty pass), key resets to 0x00
    run_pass(1, 0, "R1");

    // R3 R4 R5: single object with reset key
    set_slot(0, 10, 5, 6, 3, 'h100, 1);
    run_pass(1, 0, "R4");

    // R3 R8: overlap order, disabled and zero-size slots
    clear_all();
    set_slot(1, 20, 20, 0, 4, 'h500, 1);
    set_slot(2, 12, 6, 5, 4, 'h200, 1);
    set_slot(3, 13, 6, 4, 4, 'h600, 0);
    set_slot(5, 14, 7, 4, 2, 'h301, 1);
    set_slot(9, 30, 30, 3, 0, 'h700, 1);
    run_pass(1, 0, "R8");

    // R6: clipping on both edges and fully outside, last slot drawn
    clear_all();
    set_slot(0, 390, 292, 20, 12, 'h1000, 1);
    set_slot(1, 500, 10, 8, 2, 'h2000, 1);
    set_slot(15, 0, 299, 3, 3, 'hFFFFE, 1);
    run_pass(1, 0, "R6");

    // R4: loaded key 0x55 drops 0x55, writes 0x00
    set_key('h55);
    set_slot(4, 100, 100, 16, 2, 'h40, 1);
    run_pass(1, 0, "R4");

    // R10: random stalls
    stall_en = 1;
    run_pass(0, 0, "R10");
    stall_en = 0;

    // R7: start while busy ignored
    run_pass(1, 1, "R7");

    // R9: request alone does not flip, vblank edge while idle does
    tick(); swap_req = 1; tick(); swap_req = 0;
    repeat (4) tick();
    chk(disp_sel == 0, "R9", "no flip without vblank", disp_sel, 0);
    vblank = 1; repeat (3) tick(); vblank = 0;
    @(negedge clk);
    chk(disp_sel == 1, "R9", "flip at vblank", disp_sel, 1);
    // R2: hidden page is now page 0
    run_pass(1, 0, "R2");

    // R9: request and vblank during a pass, flip deferred to idle
    fork
      run_pass(1, 0, "R9");
      begin
        repeat (10) tick();
        swap_req = 1; tick(); swap_req = 0;
        repeat (3) tick();
        vblank = 1; repeat (3) tick(); vblank = 0;
        @(negedge clk);
        chk(disp_sel == 1, "R9", "held during pass", disp_sel, 1);
      end
    join
    repeat (3) @(negedge clk);
    chk(disp_sel == 0, "R9", "deferred flip", disp_sel, 0);

    repeat (4) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule